// File: doc/BRIEF.md
# Map register unlock write sequencer

This block watches a bus write port for a fixed chain of keyed writes. Four key writes come first, each a specific byte at a specific low address offset. A command byte follows and picks which of two map registers is the target. The next write, at any address, carries the new register value.

Only after this chain is complete does the block emit a single-cycle write enable, together with the value and a target select, to the storage that holds the map registers. That storage is not part of this block. After the update the block reports busy for a programmable number of clock cycles, the write-cycle delay, and ignores all writes during that time.

A write that breaks the chain drops the block back to idle. There is one exception: a write of 0xAA to offset 0x555 that arrives out of place is taken as the first step of a fresh chain.

Top module: `map_unlock_seq`

## Requirements
- R1: While reset is held, and right after it, `regWrEn`, `busy`, `regSel` and `regVal` are all 0.
- R2: The accepted chain is six write strobes, counted in any clock cycles.
  - Write 1: 0xAA at offset 0x555.
  - Write 2: 0x55 at offset 0xAAA.
  - Write 3: 0xA0 at offset 0x555.
  - Write 4: 0xAA at offset 0x555.
  - Write 5: command byte 0xD0 at offset 0x555.
  - Write 6: value V at any address.
  - Result: in the cycle after write 6, `regWrEn`=1, `regVal`=V and `regSel`=0.
- R3: The same chain with command byte 0xE0 gives `regSel`=1 with the value.
- R4: Only `addr[11:0]` is compared with the key offsets. The upper address bits have no effect.
- R5: During key writes 1 to 4, a write with the wrong data or the wrong offset returns the block to idle. No register write follows unless a complete new chain is given.
- R6: A write of 0xAA at 0x555 that arrives where write 2, 3 or 5 is expected restarts the chain as if write 1 had just been accepted.
- R7: A command byte other than 0xD0 or 0xE0 aborts the chain with no register write.
- R8: `busy` is high for exactly `WC_DELAY` cycles, starting in the `regWrEn` cycle. Any writes made while busy, including a full chain, cause no register write and leave `regVal` and `regSel` unchanged.
- R9: Cycles with `wrStb` low neither advance nor abort the chain.
- R10: `regWrEn` lasts one cycle. `regVal` and `regSel` keep their values until the next accepted chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStb | input | 1 | One bus write in this cycle |
| addr | input | ADDR_W | Write address |
| wdata | input | 8 | Write data |
| regWrEn | output | 1 | One-cycle map register write enable |
| regSel | output | 1 | Target register: 0 = register-window map, 1 = memory map |
| regVal | output | 8 | New register value |
| busy | output | 1 | Write-cycle delay in progress |

## Verification
The embedded assertions check the following on every cycle:
- the enable lasts one cycle and lines up with the start of busy;
- the value and target hold outside a write;
- busy keeps running while its count is not spent;
- idle cycles never move the step state;
- the wait state holds until the delay is done.

Other behaviour can only be shown by the bench's scenarios: the exact key bytes and offsets, the abort and restart outcomes at each step, the choice of target by command byte, and the immunity of the busy window to a complete chain. The bench covers these by sweeping every data byte at every step and every upper address nibble.

// File: rtl/map_unlock_pkg.sv
package map_unlock_pkg;

  localparam int KEY_W = 12;

  localparam logic [KEY_W-1:0] OFS_LO = 12'h555;
  localparam logic [KEY_W-1:0] OFS_HI = 12'hAAA;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] KEY_THIRD  = 8'hA0;
  localparam logic [7:0] CMD_WINDOW = 8'hD0;
  localparam logic [7:0] CMD_MEMMAP = 8'hE0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_K3,
    ST_CMD,
    ST_DATA,
    ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic selLoad;
    logic selTarget;
    logic commit;
  } seqStrobe_t;

endpackage

// File: rtl/map_unlock_ctrl.sv
module map_unlock_ctrl
  import map_unlock_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              delayDone,
  output seqStrobe_t        strb
);

  seqState_t state;
  seqState_t stateNext;
  logic [KEY_W-1:0] keyOfs;
  logic isRestart;
  logic hitK2;
  logic hitK3;
  logic hitK4;
  logic hitCmdWin;
  logic hitCmdMem;

  assign keyOfs    = addr[KEY_W-1:0];
  assign isRestart = wrStb && (keyOfs == OFS_LO) && (wdata == KEY_FIRST);
  assign hitK2     = wrStb && (keyOfs == OFS_HI) && (wdata == KEY_SECOND);
  assign hitK3     = wrStb && (keyOfs == OFS_LO) && (wdata == KEY_THIRD);
  assign hitK4     = isRestart;
  assign hitCmdWin = wrStb && (keyOfs == OFS_LO) && (wdata == CMD_WINDOW);
  assign hitCmdMem = wrStb && (keyOfs == OFS_LO) && (wdata == CMD_MEMMAP);

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (isRestart) stateNext = ST_K1;
      end
      ST_K1: begin
        if (hitK2)          stateNext = ST_K2;
        else if (isRestart) stateNext = ST_K1;
        else if (wrStb)     stateNext = ST_IDLE;
      end
      ST_K2: begin
        if (hitK3)          stateNext = ST_K3;
        else if (isRestart) stateNext = ST_K1;
        else if (wrStb)     stateNext = ST_IDLE;
      end
      ST_K3: begin
        if (hitK4)      stateNext = ST_CMD;
        else if (wrStb) stateNext = ST_IDLE;
      end
      ST_CMD: begin
        if (hitCmdWin || hitCmdMem) begin
          stateNext      = ST_DATA;
          strb.selLoad   = 1'b1;
          strb.selTarget = hitCmdMem;
        end else if (isRestart) begin
          stateNext = ST_K1;
        end else if (wrStb) begin
          stateNext = ST_IDLE;
        end
      end
      ST_DATA: begin
        if (wrStb) begin
          stateNext   = ST_WAIT;
          strb.commit = 1'b1;
        end
      end
      ST_WAIT: begin
        if (delayDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_IDLE_CYCLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStb && state != ST_WAIT) |=> $stable(state)); // R9

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !delayDone) |=> (state == ST_WAIT)); // R8

  AST_DATA_TO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && wrStb) |=> (state == ST_WAIT)); // R2

endmodule

// File: rtl/map_unlock_dp.sv
module map_unlock_dp
  import map_unlock_pkg::*;
#(
  parameter int WC_DELAY = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic [7:0] wdata,
  output logic       delayDone,
  output logic       regWrEn,
  output logic       regSel,
  output logic [7:0] regVal,
  output logic       busy
);

  localparam int CNT_W = (WC_DELAY < 2) ? 1 : $clog2(WC_DELAY);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WC_DELAY - 1);

  logic             pendSel;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrEn <= 1'b0;
      regSel  <= 1'b0;
      regVal  <= '0;
      pendSel <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
    end else begin
      regWrEn <= strb.commit;
      if (strb.selLoad) pendSel <= strb.selTarget;
      if (strb.commit) begin
        regVal <= wdata;
        regSel <= pendSel;
        busy   <= 1'b1;
        cnt    <= CNT_LOAD;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  assign delayDone = busy && (cnt == '0);

  AST_WREN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R10

  AST_WREN_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (busy && cnt == CNT_LOAD)); // R8

  AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> ($stable(regVal) && $stable(regSel))); // R10

  AST_BUSY_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> busy); // R8

endmodule

// File: rtl/map_unlock_seq.sv
module map_unlock_seq
  import map_unlock_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WC_DELAY = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              regWrEn,
  output logic              regSel,
  output logic [7:0]        regVal,
  output logic              busy
);

  seqStrobe_t strb;
  logic       delayDone;

  initial begin
    assert (ADDR_W >= KEY_W);
    assert (WC_DELAY >= 1);
  end

  map_unlock_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .addr      (addr),
    .wdata     (wdata),
    .delayDone (delayDone),
    .strb      (strb)
  );

  map_unlock_dp #(.WC_DELAY(WC_DELAY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (wdata),
    .delayDone (delayDone),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regVal    (regVal),
    .busy      (busy)
  );

endmodule

// File: tb/map_unlock_seq_tb.sv
module map_unlock_seq_tb;

  localparam int D = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        regWrEn;
  logic        regSel;
  logic [7:0]  regVal;
  logic        busy;

  int nChk = 0;
  int nBad = 0;
  int wrCount = 0;

  map_unlock_seq #(.ADDR_W(16), .WC_DELAY(D)) u_dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .addr(addr), .wdata(wdata),
    .regWrEn(regWrEn), .regSel(regSel), .regVal(regVal), .busy(busy)
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (rstN && regWrEn) wrCount <= wrCount + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nBad, nChk);
    $finish;
  endtask

  function automatic logic [11:0] keyOfs(int k);
    return (k == 1) ? 12'hAAA : 12'h555;
  endfunction

  function automatic logic [7:0] keyByte(int k);
    case (k)
      0: return 8'hAA;
      1: return 8'h55;
      2: return 8'hA0;
      3: return 8'hAA;
      default: return 8'hD0;
    endcase
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d, int gap = 0);
    @(negedge clk);
    wrStb = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrStb = 1'b0; addr = 16'($urandom); wdata = 8'($urandom);
    repeat (gap) @(negedge clk);
  endtask

  task automatic sendSteps(int from, int upto, logic [7:0] cmd, logic [3:0] hi, int gap);
    for (int k = from; k <= upto; k++)
      wr({hi, keyOfs(k)}, (k == 4) ? cmd : keyByte(k), gap);
  endtask

  task automatic fullSeq(logic [7:0] cmd, logic [7:0] val, logic [3:0] hi = 4'h0, int gap = 0);
    sendSteps(0, 4, cmd, hi, gap);
    wr(16'($urandom), val);
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    wr(16'h0000, 8'h00);
  endtask

  task automatic commitCheck(logic [7:0] val, logic sel, string req);
    int n;
    chk(regWrEn === 1'b1, req, regWrEn, 1);
    chk(regVal === val, req, regVal, val);
    chk(regSel === sel, req, regSel, sel);
    n = 0;
    while (busy) begin
      if (n == 1) chk(regWrEn === 1'b0, "R10", regWrEn, 0);
      n++;
      @(negedge clk);
      if (n > D + 4) break;
    end
    chk(n == D, "R8", n, D);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finishRun();
  end

  initial begin
    int c0;
    int exp;
    repeat (3) @(negedge clk);
    chk(regWrEn === 1'b0 && busy === 1'b0, "R1", {regWrEn, busy}, 0);
    chk(regVal === 8'h00 && regSel === 1'b0, "R1", {regSel, regVal}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(regWrEn === 1'b0 && busy === 1'b0 && regVal === 8'h00, "R1", {busy, regVal}, 0);

    fullSeq(8'hD0, 8'h3C);
    commitCheck(8'h3C, 1'b0, "R2");

    fullSeq(8'hE0, 8'hC5);
    commitCheck(8'hC5, 1'b1, "R3");
    repeat (5) @(negedge clk);
    chk(regVal === 8'hC5 && regSel === 1'b1, "R10", {regSel, regVal}, 9'h1C5);

    for (int hi = 0; hi < 16; hi++) begin
      fullSeq((hi % 2) ? 8'hE0 : 8'hD0, 8'(hi * 17), 4'(hi));
      commitCheck(8'(hi * 17), 1'(hi % 2), "R4");
    end

    fullSeq(8'hD0, 8'h81, 4'h0, 3);
    commitCheck(8'h81, 1'b0, "R9");

    // R8: a full chain during busy is ignored
    c0 = wrCount;
    fullSeq(8'hD0, 8'h11);
    fullSeq(8'hE0, 8'h77);
    drain();
    chk(wrCount - c0 == 1, "R8", wrCount - c0, 1);
    chk(regVal === 8'h11 && regSel === 1'b0, "R8", {regSel, regVal}, 9'h011);

    // R5 / R7: every data byte at every step
    for (int k = 0; k < 5; k++) begin
      for (int b = 0; b < 256; b++) begin
        drain();
        c0 = wrCount;
        sendSteps(0, k - 1, 8'hD0, 4'h0, 0);
        wr({4'h0, keyOfs(k)}, 8'(b));
        sendSteps(k + 1, 4, 8'hD0, 4'h0, 0);
        wr(16'($urandom), 8'h5A);
        @(negedge clk);
        if (k < 4) exp = (8'(b) == keyByte(k)) ? 1 : 0;
        else       exp = (b == 'hD0 || b == 'hE0) ? 1 : 0;
        chk(wrCount - c0 == exp, (k == 4) ? "R7" : "R5", wrCount - c0, exp);
        if (exp == 1 && k == 4)
          chk(regSel === (b == 'hE0), "R3", regSel, (b == 'hE0));
      end
    end

    // R5: wrong offset at each key step
    for (int k = 0; k < 5; k++) begin
      drain();
      c0 = wrCount;
      sendSteps(0, k - 1, 8'hD0, 4'h0, 0);
      wr({4'h0, keyOfs(k) ^ 12'h001}, (k == 4) ? 8'hD0 : keyByte(k));
      sendSteps(k + 1, 4, 8'hD0, 4'h0, 0);
      wr(16'($urandom), 8'h5A);
      @(negedge clk);
      chk(wrCount - c0 == 0, "R5", wrCount - c0, 0);
    end

    // R6: out-of-place 0xAA at 0x555 restarts the chain
    for (int k = 1; k < 5; k++) begin
      drain();
      c0 = wrCount;
      sendSteps(0, k - 1, 8'hD0, 4'h0, 0);
      wr(16'h0555, 8'hAA);
      sendSteps(1, 4, 8'hE0, 4'h0, 0);
      wr(16'($urandom), 8'h6B);
      @(negedge clk);
      exp = (k == 3) ? 0 : 1;
      chk(wrCount - c0 == exp, "R6", wrCount - c0, exp);
      if (exp == 1) chk(regVal === 8'h6B && regSel === 1'b1, "R6", {regSel, regVal}, 9'h16B);
    end

    drain();
    finishRun();
  end

endmodule